// File: doc/BRIEF.md
# Frame-Synchronous Byte Descrambler

This block removes the frame-synchronous scrambling from a byte-wide, high-rate optical-transport data stream. Each valid input byte is combined with eight steps of a 7-bit pseudo-random sequence, built on the polynomial 1 + x^6 + x^7. The most significant bit of the byte takes the first step. The result leaves the block one clock later, together with a delayed valid flag.

A frame counter upstream sends `frm_start` on the first framing byte of each frame. The block then counts the framing and trace bytes at the start of row 1 (`ROW1_BYTES`, 144 for a 48-way interleave). These bytes pass through unchanged. The sequence register is loaded with all ones exactly at the most significant bit of the next byte. From there the sequence steps on every valid byte until the next frame start. When `descr_en` is low the block stays on the frame and keeps the sequence in step, but it forwards every byte unchanged.

The control unit has four states:
- `ST_HUNT`: the state after reset, with no frame seen yet.
- `ST_OVH`: counting through the row-1 overhead.
- `ST_SEED`: the next valid byte loads the sequence.
- `ST_RUN`: descrambling.

The transitions are:
- **restart**: any state goes to `ST_OVH` on a valid byte with `frm_start` (to `ST_SEED` if `ROW1_BYTES` is 1).
- **overhead done**: `ST_OVH` goes to `ST_SEED` on the last overhead byte.
- **seed**: `ST_SEED` goes to `ST_RUN` on the next valid byte.
- **hold**: every state stays where it is on cycles without a valid byte.

Top module: `byte_descrambler`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock; the output path has a latency of exactly one register stage whether or not descrambling is enabled.
- R2: After reset, `out_valid` and `out_data` are both 0.
- R3: The valid byte carrying `frm_start`, and the next `ROW1_BYTES`-1 valid bytes, appear at the output unchanged.
- R4: The first valid byte after the row-1 overhead is XORed with 0xFE, the keystream from an all-ones register. Bit 7 is the first sequence bit.
- R5: Each later valid byte is XORed with the next 8 sequence bits b[n] = b[n-6] XOR b[n-7], with the earliest bit on bit 7. The keystream repeats every 127 bits, so the byte 127 bytes after the seed byte again sees 0xFE.
- R6: A cycle with `in_valid` low advances neither the sequence nor the overhead count, and `out_data` keeps its previous value.
- R7: With `descr_en` low, every valid byte is output unchanged, while counting and sequence stepping go on. Re-enabling resumes in phase.
- R8: A valid byte with `frm_start` in any state, including mid-overhead or mid-payload, restarts the overhead count. That byte passes unchanged, and the sequence reloads after the new overhead.
- R9: Before the first `frm_start` after reset, valid bytes pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Scrambled input byte |
| in_valid | input | 1 | Input byte qualifier |
| frm_start | input | 1 | Marks the first framing byte of a frame (sampled with `in_valid`) |
| descr_en | input | 1 | 1 = descramble, 0 = bypass |
| out_data | output | 8 | Descrambled byte, one clock after input |
| out_valid | output | 1 | Delayed `in_valid` |

## Verification
The assertions assume three things about the inputs:
- `frm_start` has meaning only together with `in_valid`.
- The frame counter upstream never marks a frame start more often than the block can count, since the overhead counter must stay below `ROW1_BYTES`.
- The inputs are steady around the clock edge.

The stimulus drives all inputs a short time after each rising edge. It raises `frm_start` only on valid bytes, at frame starts or at a deliberate restart inside the overhead or payload. It scatters idle cycles and enable toggles across all four states, so the hold and bypass properties are exercised in each of them.

// File: rtl/bdscr_pkg.sv
package bdscr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OVH  = 2'd1,
        ST_SEED = 2'd2,
        ST_RUN  = 2'd3
    } dscr_state_e;
endpackage

// File: rtl/bdscr_keygen.sv
// Sequence generator: produces BYTE_W successive steps per advance, first step on the MSB.
module bdscr_keygen #(
    parameter int BYTE_W   = 8,
    parameter int SEQ_LEN  = 7,
    parameter int SEQ_TAP  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [BYTE_W-1:0] key
);
    localparam logic [SEQ_LEN-1:0] ALL_ONES = {SEQ_LEN{1'b1}};

    logic [SEQ_LEN-1:0]            seq_q;
    logic [BYTE_W:0][SEQ_LEN-1:0]  chain;

    // Loading happens at the first bit of the current byte, so the byte sees the fresh seed.
    assign chain[0] = load ? ALL_ONES : seq_q;

    for (genvar g = 0; g < BYTE_W; g++) begin : g_step
        assign key[BYTE_W-1-g] = chain[g][SEQ_LEN-1];
        assign chain[g+1]      = {chain[g][SEQ_LEN-2:0],
                                  chain[g][SEQ_LEN-1] ^ chain[g][SEQ_TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= ALL_ONES;
        end else if (load || adv) begin
            seq_q <= chain[BYTE_W];
        end
    end

    // R6: the register moves only when a byte consumes the keystream
    assert_seq_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(seq_q));

    // R5: a maximal-length register never falls into the all-zero lock-up state
    assert_seq_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q != '0);
endmodule

// File: rtl/bdscr_ctrl.sv
// Frame-position control: tracks row-1 overhead and tells the generator when to seed and step.
module bdscr_ctrl
    import bdscr_pkg::*;
#(
    parameter int ROW1_BYTES = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic frm_start,
    output logic gen_load,
    output logic gen_adv,
    output logic xor_sel
);
    localparam int CNT_W = (ROW1_BYTES < 2) ? 1 : $clog2(ROW1_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROW1_BYTES - 1);
    localparam dscr_state_e AFTER_START = (ROW1_BYTES > 1) ? ST_OVH : ST_SEED;

    dscr_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (in_valid) begin
            if (frm_start) begin
                st_d  = AFTER_START;
                cnt_d = (ROW1_BYTES > 1) ? CNT_W'(1) : '0;
            end else begin
                unique case (st_q)
                    ST_HUNT: st_d = ST_HUNT;
                    ST_OVH: begin
                        if (cnt_q == LAST_IDX) begin
                            st_d  = ST_SEED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                    ST_SEED: st_d = ST_RUN;
                    ST_RUN:  st_d = ST_RUN;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        gen_load = 1'b0;
        gen_adv  = 1'b0;
        if (in_valid && !frm_start) begin
            unique case (st_q)
                ST_HUNT: ;
                ST_OVH:  ;
                ST_SEED: gen_load = 1'b1;
                ST_RUN:  gen_adv  = 1'b1;
            endcase
        end
        xor_sel = gen_load || gen_adv;
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frm_start) |=> (st_q == AFTER_START));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q) && $stable(cnt_q)));

    assert_seed_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEED && in_valid && !frm_start) |=> (st_q == ST_RUN));
endmodule

// File: rtl/bdscr_outreg.sv
// Single output register shared by the descramble and bypass paths.
module bdscr_outreg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic [BYTE_W-1:0] key,
    input  logic              xor_sel,
    input  logic              descr_en,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);
    logic [BYTE_W-1:0] mask;

    assign mask = (xor_sel && descr_en) ? key : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data ^ mask;
            end
        end
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !descr_en) |=> (out_data == $past(in_data)));

    assert_ovh_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !xor_sel) |=> (out_data == $past(in_data)));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: rtl/byte_descrambler.sv
module byte_descrambler #(
    parameter int BYTE_W     = 8,
    parameter int ROW1_BYTES = 144,
    parameter int SEQ_LEN    = 7,
    parameter int SEQ_TAP    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              frm_start,
    input  logic              descr_en,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid
);
    logic              gen_load;
    logic              gen_adv;
    logic              xor_sel;
    logic [BYTE_W-1:0] key;

    bdscr_ctrl #(.ROW1_BYTES(ROW1_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .frm_start (frm_start),
        .gen_load  (gen_load),
        .gen_adv   (gen_adv),
        .xor_sel   (xor_sel)
    );

    bdscr_keygen #(.BYTE_W(BYTE_W), .SEQ_LEN(SEQ_LEN), .SEQ_TAP(SEQ_TAP)) u_keygen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gen_load),
        .adv   (gen_adv),
        .key   (key)
    );

    bdscr_outreg #(.BYTE_W(BYTE_W)) u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .key       (key),
        .xor_sel   (xor_sel),
        .descr_en  (descr_en),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // R4: with the standard eight-bit byte and 7-bit sequence, the seed byte sees 0xFE
    if (BYTE_W == 8 && SEQ_LEN == 7 && SEQ_TAP == 6) begin : g_seed_chk
        assert_seed_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
            gen_load |-> (key == 8'hFE));
    end
endmodule

// File: tb/sim_byte_descrambler.sv
`timescale 1ns/1ps
module sim_byte_descrambler;
    localparam int ROW1 = 144;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_data;
    logic       in_valid;
    logic       frm_start;
    logic       descr_en;
    logic [7:0] out_data;
    logic       out_valid;

    always #2.5 clk = ~clk;

    byte_descrambler #(.ROW1_BYTES(ROW1)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .frm_start (frm_start),
        .descr_en  (descr_en),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;
    bit   seq [127];
    int   phase = 0;      // 0 hunt, 1 overhead, 2 seed next, 3 running
    int   seen  = 0;
    int   pos   = 0;
    logic [7:0] exp_d = 8'h00;
    logic       exp_v = 1'b0;

    function automatic logic [7:0] key_at(int p);
        logic [7:0] k;
        for (int b = 0; b < 8; b++) k[7-b] = seq[(p + b) % 127];
        return k;
    endfunction

    task automatic chk(string req, logic [8:0] act, logic [8:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(logic [7:0] d, bit v, bit s, bit e);
        string      tag;
        logic [7:0] k;
        bit         app;
        in_data   = d;
        in_valid  = v;
        frm_start = s;
        descr_en  = e;
        app = 0;
        k   = 8'h00;
        tag = "R6";
        if (v) begin
            if (s) begin
                tag = "R8";
                phase = (ROW1 > 1) ? 1 : 2;
                seen  = 1;
            end else begin
                case (phase)
                    0: tag = "R9";
                    1: begin
                        tag = "R3";
                        seen++;
                        if (seen == ROW1) phase = 2;
                    end
                    2: begin
                        tag = "R4";
                        k = key_at(0);
                        app = 1;
                        pos = 8;
                        phase = 3;
                    end
                    default: begin
                        tag = "R5";
                        k = key_at(pos);
                        app = 1;
                        pos = (pos + 8) % 127;
                    end
                endcase
            end
            if (!e) tag = "R7";
            exp_d = (app && e) ? (d ^ k) : d;
        end
        exp_v = v;
        @(posedge clk);
        #1;
        chk({tag, "/R1"}, {out_valid, out_data}, {exp_v, exp_d});
    endtask

    task automatic run_bytes(int n, int idle_pct, int off_pct);
        for (int i = 0; i < n; i++) begin
            bit v = ($urandom % 100) >= idle_pct;
            bit e = ($urandom % 100) >= off_pct;
            step(8'($urandom), v, 1'b0, e);
        end
    endtask

    initial begin
        for (int i = 0; i < 7; i++) seq[i] = 1'b1;
        for (int i = 7; i < 127; i++) seq[i] = seq[i-6] ^ seq[i-7];

        rst_n = 1'b0; in_data = 8'h00; in_valid = 1'b0; frm_start = 1'b0; descr_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R2", {out_valid, out_data}, 9'h000);
        rst_n = 1'b1;

        // Hunting: nothing scrambled before any frame
        run_bytes(20, 20, 0);

        // Frame 1: overhead with gaps, seed on zero byte, full period of zeros
        step(8'hF6, 1, 1, 1);
        for (int i = 0; i < ROW1 - 1; i++) begin
            if ($urandom % 6 == 0) step(8'($urandom), 0, 0, 1);
            step(8'($urandom), 1, 0, 1);
        end
        step(8'h00, 1, 0, 1);
        chk("R4", {1'b1, out_data}, {1'b1, 8'hFE});
        for (int i = 0; i < 126; i++) step(8'h00, 1, 0, 1);
        step(8'h00, 1, 0, 1);
        chk("R5", {1'b1, out_data}, {1'b1, 8'hFE});
        run_bytes(250, 25, 20);

        // Frame 2: restart mid-payload, bypass toggling through overhead and payload
        step(8'h28, 1, 1, 0);
        run_bytes(ROW1 + 40, 15, 40);
        run_bytes(200, 10, 10);

        // Frame 3: restart inside overhead, then normal completion
        step(8'hF6, 1, 1, 1);
        run_bytes(50, 10, 0);
        step(8'hF6, 1, 1, 1);
        run_bytes(ROW1 + 300, 20, 15);

        // Frame 4: seed byte arrives while bypassed, re-enable resumes in phase
        step(8'hF6, 1, 1, 1);
        for (int i = 0; i < ROW1 - 1; i++) step(8'($urandom), 1, 0, 1);
        step(8'h5A, 1, 0, 0);
        run_bytes(60, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule